// File: doc/BRIEF.md
# Errored Packet Drop Filter

This block sits on a wide receive user data path. Each beat carries up to eight 64-bit words, along with a count of the valid words in the beat, a start-of-packet flag and an end field. The end field holds an end-of-packet bit and the number of valid bytes in the last valid word. Each beat also carries an error flag. Every beat of a packet is written into an internal packet buffer as it arrives, and the packet's exact byte length is accumulated at the same time.

At the final beat the block decides what happens to the packet. A clean packet is committed and becomes visible on the output stream, and its length is reported on a one-cycle side channel. A packet that carries the error flag on its final beat is rolled back, and none of its beats ever reach the output. This holds even when its end fields look well formed. The same rollback applies to a packet that found the buffer full.

Three counters record committed packets, errored drops and overflow drops. The output side is a plain valid/ready stream of whole beats. The receive side has no back-pressure.

Top module: `edf_drop_filter`

## Requirements
- R1: A beat takes part only when `in_valid` is high and the 4-bit `in_words` is non-zero. Its value 1 to 8 is the number of valid 64-bit words, so 4'b0111 means seven.
- R2: Bit 3 of `in_end` marks the last beat of a packet, and bits 2:0 give the valid bytes in the last valid word, with 3'b000 meaning eight. A non-final beat adds 8×words bytes. The final beat adds 8×(words−1) plus the last-word byte count. For example, 16 earlier words followed by a final beat of seven words and 3'b011 give 179 bytes.
- R3: A committed packet raises `len_valid` for exactly one cycle, in the cycle after its final beat is sampled. In that cycle `len_bytes` carries the packet's length and `good_cnt` rises by one.
- R4: When `in_err` is high on a packet's final beat, no beat of that packet appears on the output and `len_valid` stays low. `drop_cnt` rises by one in the cycle after that beat.
- R5: Beats that do not take part leave the packet state, the counters and the length channel unchanged, whatever their other fields hold.
- R6: Committed beats leave on `out_*` in arrival order with their data, word count, start flag and end field unchanged. Beats of a packet appear only after its final beat has been sampled. While `out_valid` is high and `out_ready` is low, the output beat holds steady.
- R7: The buffer holds DEPTH beats, counting committed beats not yet moved to the output register plus the current packet's beats. When a beat arrives with no free entry, the packet is overflowed: none of it is output, no length is reported, and `ovf_cnt` rises by one at its final beat.
- R8: A packet that is both overflowed and errored counts only in `drop_cnt`.
- R9: After a synchronous active-high reset, `out_valid` and `len_valid` are low and all three counters are zero.
- R10: A start-of-packet beat abandons any unfinished packet. The abandoned beats are never output, and the length count restarts from the new beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive beat qualifier |
| in_words | input | 4 | Number of valid 64-bit words in the beat |
| in_sop | input | 1 | Start of packet |
| in_end | input | 4 | Bit 3 end of packet, bits 2:0 valid bytes in last word (0 = 8) |
| in_err | input | 1 | Packet errored (acted on at end of packet) |
| in_data | input | 512 | Beat payload, word k in bits 64k+63:64k |
| out_ready | input | 1 | Output consumer ready |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 512 | Output beat payload |
| out_words | output | 4 | Output beat valid word count |
| out_sop | output | 1 | Output start of packet |
| out_end | output | 4 | Output end field, same coding as `in_end` |
| len_valid | output | 1 | One-cycle pulse per committed packet |
| len_bytes | output | 16 | Byte length of the committed packet |
| good_cnt | output | 16 | Committed packet count |
| drop_cnt | output | 16 | Errored packet count |
| ovf_cnt | output | 16 | Overflowed packet count |

## Verification
The bench feeds a 179-byte packet, and then the same packet with the error flag set on its last beat. A design that looked only at the end fields would pass the errored copy through and count it as good. It then checks the last-byte value of zero and single-beat packets, because a decoder that reads 3'b000 as zero or drops the last word's bytes reports wrong lengths. It inserts non-taking-part beats that carry start, end and error flags in the middle of a packet, and a second start that abandons a partial packet. A filter that reacts to these flags would emit stale beats or miscount. It stalls the output until the buffer fills, alone and with an error on the overflowed packet, to catch a partial overflowed packet leaking out and a packet counted in both drop counters. Random back-pressure checks ordering and output hold.

// File: rtl/edf_pkg.sv
package edf_pkg;

  // Outcome of a packet decided on its final beat.
  typedef enum logic [1:0] {
    FATE_NONE = 2'd0,
    FATE_GOOD = 2'd1,
    FATE_DROP = 2'd2,
    FATE_OVF  = 2'd3
  } fate_e;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/edf_len_track.sv
module edf_len_track #(
  parameter  int LANES  = 8,
  parameter  int WORD_W = 64,
  parameter  int LEN_W  = 16,
  localparam int CW     = $clog2(LANES + 1),
  localparam int BPW    = WORD_W / edf_pkg::BYTE_BITS,
  localparam int LBW    = $clog2(BPW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             sop,
  input  logic             eop,
  input  logic [CW-1:0]    words,
  input  logic [LBW-1:0]   lb,
  output logic [LEN_W-1:0] len_now
);

  logic [LEN_W-1:0] acc;
  logic [LEN_W-1:0] beat_len;
  logic [LEN_W-1:0] tail_len;

  // Bytes contributed by this beat; a zero last-word count means a full word.
  always_comb begin
    tail_len = (lb == '0) ? LEN_W'(BPW) : LEN_W'(lb);
    if (eop) beat_len = (LEN_W'(words) - LEN_W'(1)) * LEN_W'(BPW) + tail_len;
    else     beat_len = LEN_W'(words) * LEN_W'(BPW);
    len_now = (sop ? '0 : acc) + beat_len;
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (act) acc <= len_now;
  end

  // R5: beats that do not take part leave the running length alone
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !act |=> $stable(acc));

  // R2: a taking-part beat always adds at least one byte
  a_r2_beat_nonzero: assert property (@(posedge clk) disable iff (rst)
    act |-> beat_len != '0);

endmodule

// File: rtl/edf_pkt_buf.sv
// Beat-wide packet buffer with a tentative write pointer. DEPTH must be a
// power of two; pointers carry one extra bit to tell full from empty.
module edf_pkt_buf #(
  parameter  int DEPTH = 16,
  parameter  int EW    = 520,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_act,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          commit,
  input  logic          rollback,
  input  logic [EW-1:0] wr_entry,
  input  logic          out_ready,
  output logic          pkt_ovf,
  output logic          out_valid,
  output logic [EW-1:0] out_entry
);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] tent_ptr, cmt_ptr, rd_ptr;
  logic [PW-1:0] base, used;
  logic          ovf_q, ovf_prev, room, wr_ok, ld;

  always_comb begin
    base     = wr_sop ? cmt_ptr : tent_ptr;
    used     = base - rd_ptr;
    room     = used < PW'(DEPTH);
    ovf_prev = wr_sop ? 1'b0 : ovf_q;
    wr_ok    = wr_act && !ovf_prev && room;
    pkt_ovf  = ovf_prev || !room;
    ld       = (!out_valid || out_ready) && (rd_ptr != cmt_ptr);
  end

  // Memory write port (no reset, block RAM friendly).
  always_ff @(posedge clk) begin
    if (wr_ok) mem[base[AW-1:0]] <= wr_entry;
  end

  // Registered read port with enable feeds the output register directly.
  always_ff @(posedge clk) begin
    if (ld) out_entry <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tent_ptr  <= '0;
      cmt_ptr   <= '0;
      rd_ptr    <= '0;
      ovf_q     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (commit) begin
        cmt_ptr  <= base + PW'(1);
        tent_ptr <= base + PW'(1);
      end else if (rollback) begin
        tent_ptr <= cmt_ptr;
      end else if (wr_ok) begin
        tent_ptr <= base + PW'(1);
      end else if (wr_act && wr_sop) begin
        tent_ptr <= cmt_ptr;
      end
      if (wr_act) ovf_q <= wr_eop ? 1'b0 : pkt_ovf;
      if (ld) begin
        rd_ptr    <= rd_ptr + PW'(1);
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: the buffer never holds more than DEPTH beats
  a_r7_no_overfill: assert property (@(posedge clk) disable iff (rst)
    (PW'(tent_ptr - rd_ptr) <= PW'(DEPTH)) && (PW'(cmt_ptr - rd_ptr) <= PW'(DEPTH)));

  // R4: a rollback leaves no tentative beat behind
  a_r4_rollback_clean: assert property (@(posedge clk) disable iff (rst)
    rollback |=> tent_ptr == cmt_ptr);

  // R6: a stalled output beat holds steady
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));

  // R6: reads never run ahead of the committed point
  a_r6_committed_only: assert property (@(posedge clk) disable iff (rst)
    PW'(cmt_ptr - rd_ptr) <= PW'(tent_ptr - rd_ptr) || rollback);

endmodule

// File: rtl/edf_pkt_stats.sv
module edf_pkt_stats #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  edf_pkg::fate_e    fate,
  input  logic [LEN_W-1:0]  len_in,
  output logic              len_valid,
  output logic [LEN_W-1:0]  len_bytes,
  output logic [CNT_W-1:0]  good_cnt,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic [CNT_W-1:0]  ovf_cnt
);

  import edf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_valid <= 1'b0;
      len_bytes <= '0;
      good_cnt  <= '0;
      drop_cnt  <= '0;
      ovf_cnt   <= '0;
    end else begin
      len_valid <= (fate == FATE_GOOD);
      if (fate == FATE_GOOD) begin
        len_bytes <= len_in;
        good_cnt  <= good_cnt + CNT_W'(1);
      end
      if (fate == FATE_DROP) drop_cnt <= drop_cnt + CNT_W'(1);
      if (fate == FATE_OVF)  ovf_cnt  <= ovf_cnt + CNT_W'(1);
    end
  end

  // R3: every length pulse goes with one more good packet
  a_r3_pulse_counts: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> good_cnt == $past(good_cnt) + CNT_W'(1));

  // R4: drops move by at most one per cycle and never with a length pulse
  a_r4_drop_step: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + CNT_W'(1)) && !len_valid);

  // R8: a packet lands in one counter only
  a_r8_single_bucket: assert property (@(posedge clk) disable iff (rst)
    (ovf_cnt != $past(ovf_cnt)) |-> $stable(drop_cnt) && !len_valid);

endmodule

// File: rtl/edf_drop_filter.sv
module edf_drop_filter #(
  parameter  int LANES  = 8,
  parameter  int WORD_W = 64,
  parameter  int DEPTH  = 16,
  parameter  int LEN_W  = 16,
  parameter  int CNT_W  = 16,
  localparam int CW     = $clog2(LANES + 1),
  localparam int LBW    = $clog2(WORD_W / edf_pkg::BYTE_BITS),
  localparam int DW     = LANES * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CW-1:0]     in_words,
  input  logic              in_sop,
  input  logic [LBW:0]      in_end,
  input  logic              in_err,
  input  logic [DW-1:0]     in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic [CW-1:0]     out_words,
  output logic              out_sop,
  output logic [LBW:0]      out_end,
  output logic              len_valid,
  output logic [LEN_W-1:0]  len_bytes,
  output logic [CNT_W-1:0]  good_cnt,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic [CNT_W-1:0]  ovf_cnt
);

  import edf_pkg::*;

  localparam int EW = 1 + (LBW + 1) + CW + DW;

  logic             act, eop, end_act, pkt_ovf, commit, rollback;
  logic [LEN_W-1:0] len_now;
  logic [EW-1:0]    wr_entry, rd_entry;
  fate_e            fate;

  assign act      = in_valid && (in_words != '0);
  assign eop      = in_end[LBW];
  assign end_act  = act && eop;
  assign wr_entry = {in_sop, in_end, in_words, in_data};

  // Final-beat decision: error wins over overflow, overflow over commit.
  always_comb begin
    fate = FATE_NONE;
    if (end_act) begin
      if (in_err)       fate = FATE_DROP;
      else if (pkt_ovf) fate = FATE_OVF;
      else              fate = FATE_GOOD;
    end
  end

  assign commit   = (fate == FATE_GOOD);
  assign rollback = end_act && !commit;

  edf_len_track #(
    .LANES (LANES),
    .WORD_W(WORD_W),
    .LEN_W (LEN_W)
  ) len_i (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .sop    (in_sop),
    .eop    (eop),
    .words  (in_words),
    .lb     (in_end[LBW-1:0]),
    .len_now(len_now)
  );

  edf_pkt_buf #(
    .DEPTH(DEPTH),
    .EW   (EW)
  ) buf_i (
    .clk      (clk),
    .rst      (rst),
    .wr_act   (act),
    .wr_sop   (in_sop),
    .wr_eop   (eop),
    .commit   (commit),
    .rollback (rollback),
    .wr_entry (wr_entry),
    .out_ready(out_ready),
    .pkt_ovf  (pkt_ovf),
    .out_valid(out_valid),
    .out_entry(rd_entry)
  );

  assign out_data  = rd_entry[DW-1:0];
  assign out_words = rd_entry[DW +: CW];
  assign out_end   = rd_entry[DW+CW +: LBW+1];
  assign out_sop   = rd_entry[EW-1];

  edf_pkt_stats #(
    .LEN_W(LEN_W),
    .CNT_W(CNT_W)
  ) stats_i (
    .clk      (clk),
    .rst      (rst),
    .fate     (fate),
    .len_in   (len_now),
    .len_valid(len_valid),
    .len_bytes(len_bytes),
    .good_cnt (good_cnt),
    .drop_cnt (drop_cnt),
    .ovf_cnt  (ovf_cnt)
  );

  // R5: a cycle without a taking-part beat changes no counter or length pulse
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !act |=> $stable(good_cnt) && $stable(drop_cnt) && $stable(ovf_cnt) && !len_valid);

  // R4: an errored final beat never produces a length pulse
  a_r4_err_no_len: assert property (@(posedge clk) disable iff (rst)
    (end_act && in_err) |=> !len_valid);

endmodule

// File: tb/edf_drop_filter_tb_top.sv
`timescale 1ns/1ps
module edf_drop_filter_tb_top;

  localparam int LANES = 8, WORD_W = 64, DEPTH = 16, LEN_W = 16, CNT_W = 16;
  localparam int DW = LANES * WORD_W;

  typedef struct packed {
    logic [DW-1:0] d;
    logic [3:0]    w;
    logic          s;
    logic [3:0]    en;
  } beat_s;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              in_valid = 0, in_sop = 0, in_err = 0, out_ready = 1;
  logic [3:0]        in_words = 0, in_end = 0;
  logic [DW-1:0]     in_data = '0;
  logic              out_valid, out_sop, len_valid;
  logic [DW-1:0]     out_data;
  logic [3:0]        out_words, out_end;
  logic [LEN_W-1:0]  len_bytes;
  logic [CNT_W-1:0]  good_cnt, drop_cnt, ovf_cnt;

  edf_drop_filter #(.LANES(LANES), .WORD_W(WORD_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words), .in_sop(in_sop),
    .in_end(in_end), .in_err(in_err), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_words(out_words), .out_sop(out_sop),
    .out_end(out_end), .len_valid(len_valid), .len_bytes(len_bytes),
    .good_cnt(good_cnt), .drop_cnt(drop_cnt), .ovf_cnt(ovf_cnt));

  int checks = 0, failures = 0;
  int seq = 1;
  bit done = 0, rand_rdy = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint a, input longint e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  beat_s tq[$], cq[$];
  beat_s m_out;
  bit    m_ov = 0, m_ovf = 0, m_lv = 0;
  int    m_acc = 0, m_len = 0, m_good = 0, m_drop = 0, m_ovfc = 0;
  int    n_out = 0;

  always @(posedge clk) begin
    if (rst) begin
      tq.delete(); cq.delete();
      m_ov = 0; m_ovf = 0; m_lv = 0; m_acc = 0; m_len = 0;
      m_good = 0; m_drop = 0; m_ovfc = 0; n_out = 0;
    end else begin
      bit    act, room;
      int    used, bytes;
      beat_s b;
      if (out_valid && out_ready) n_out++;
      act  = in_valid && (in_words != 0);
      used = cq.size() + ((act && in_sop) ? 0 : tq.size());
      room = used < DEPTH;
      m_lv = 0;
      if ((!m_ov || out_ready) && cq.size() > 0) begin
        m_out = cq.pop_front();
        m_ov  = 1;
      end else if (out_ready) begin
        m_ov = 0;
      end
      if (act) begin
        if (in_sop) begin tq.delete(); m_ovf = 0; m_acc = 0; end
        if (in_end[3]) bytes = (int'(in_words) - 1) * 8 + ((in_end[2:0] == 0) ? 8 : int'(in_end[2:0]));
        else           bytes = int'(in_words) * 8;
        m_acc = (m_acc + bytes) % 65536;
        b.d = in_data; b.w = in_words; b.s = in_sop; b.en = in_end;
        if (!m_ovf && room) tq.push_back(b);
        else m_ovf = 1;
        if (in_end[3]) begin
          if (in_err)     m_drop++;
          else if (m_ovf) m_ovfc++;
          else begin
            m_good++; m_lv = 1; m_len = m_acc;
            foreach (tq[i]) cq.push_back(tq[i]);
          end
          tq.delete(); m_ovf = 0;
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  int last_len = 0, n_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (len_valid) begin last_len = int'(len_bytes); n_len++; end
      chk(out_valid === m_ov, "R6", "out_valid", out_valid, m_ov);
      if (m_ov && out_valid) begin
        chk(out_data === m_out.d, "R6", "out_data[63:0]", out_data[63:0], m_out.d[63:0]);
        chk({out_words, out_sop, out_end} === {m_out.w, m_out.s, m_out.en}, "R6", "out ctl",
            {out_words, out_sop, out_end}, {m_out.w, m_out.s, m_out.en});
      end
      chk(len_valid === m_lv, "R3", "len_valid", len_valid, m_lv);
      if (m_lv) chk(int'(len_bytes) == m_len, "R2", "len_bytes", len_bytes, m_len);
      chk(int'(good_cnt) == m_good, "R3", "good_cnt", good_cnt, m_good);
      chk(int'(drop_cnt) == m_drop, "R4", "drop_cnt", drop_cnt, m_drop);
      chk(int'(ovf_cnt) == m_ovfc, "R7", "ovf_cnt", ovf_cnt, m_ovfc);
    end
  end

  always @(negedge clk) if (rand_rdy) out_ready = 1'($urandom % 2);

  // ---------------- stimulus ----------------
  task automatic beat(input int w, input bit s, input bit e, input int lb, input bit er);
    @(negedge clk);
    in_valid = 1; in_words = 4'(w); in_sop = s; in_end = {e, 3'(lb)}; in_err = er;
    for (int k = 0; k < LANES; k++) in_data[k*WORD_W +: WORD_W] = {32'(seq), 32'(k)};
    seq++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; in_words = 0; in_sop = 0; in_end = 0; in_err = 0;
    end
  endtask

  // packet of nb full beats, last beat with lw words and lb bytes
  task automatic pkt(input int nb, input int lw, input int lb, input bit er);
    for (int i = 0; i < nb; i++)
      beat((i == nb - 1) ? lw : 8, i == 0, i == nb - 1, (i == nb - 1) ? lb : 0, (i == nb - 1) && er);
  endtask

  initial begin
    int base_out;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 0, "R9", "out_valid after reset", out_valid, 0);
    chk(len_valid == 0, "R9", "len_valid after reset", len_valid, 0);
    chk(good_cnt == 0 && drop_cnt == 0 && ovf_cnt == 0, "R9", "counters after reset",
        good_cnt + drop_cnt + ovf_cnt, 0);

    // R2: 16 full words then 7 words with 3 bytes -> 179
    pkt(3, 7, 3, 0); idle(4);
    chk(last_len == 179, "R2", "179-byte length", last_len, 179);
    chk(good_cnt == 1, "R3", "good after first", good_cnt, 1);

    // R4: same packet errored on its final beat
    pkt(3, 7, 3, 1); idle(4);
    chk(drop_cnt == 1, "R4", "drop count", drop_cnt, 1);
    chk(n_len == 1, "R4", "no length pulse for errored", n_len, 1);

    // two idle cycles then 139 bytes
    idle(2); pkt(3, 2, 3, 0); idle(4);
    chk(last_len == 139, "R2", "139-byte length", last_len, 139);

    // R2: last-word byte count of zero means eight bytes
    pkt(1, 1, 0, 0); idle(3);
    chk(last_len == 8, "R2", "single word lb=0", last_len, 8);
    pkt(1, 8, 5, 0); idle(3);
    chk(last_len == 61, "R2", "single beat 8 words lb=5", last_len, 61);

    // R1 / R5: non-taking-part beats carrying flags mid packet
    beat(3, 1, 0, 0, 0);
    beat(0, 1, 1, 2, 1);
    @(negedge clk); in_valid = 0; in_words = 5; in_sop = 1; in_end = 4'b1001; in_err = 1;
    beat(2, 0, 1, 7, 0); idle(4);
    chk(last_len == 39, "R5", "length across ignored beats", last_len, 39);
    chk(good_cnt == 5 && drop_cnt == 1, "R1", "counts across ignored beats", good_cnt, 5);

    // R10: new start abandons a partial packet
    base_out = n_out;
    beat(4, 1, 0, 0, 0);
    beat(1, 1, 1, 4, 0); idle(5);
    chk(last_len == 4, "R10", "restart length", last_len, 4);
    chk(n_out - base_out == 1, "R10", "only restarted beat output", n_out - base_out, 1);

    // R7: overflow while output stalled
    idle(4); out_ready = 0; base_out = n_out;
    pkt(10, 8, 0, 0);
    pkt(10, 8, 0, 0);
    idle(2); out_ready = 1; idle(20);
    chk(ovf_cnt == 1, "R7", "overflow count", ovf_cnt, 1);
    chk(good_cnt == 7, "R7", "good after overflow", good_cnt, 7);
    chk(n_out - base_out == 10, "R7", "beats out in overflow test", n_out - base_out, 10);

    // R8: overflowed and errored counts as drop only
    out_ready = 0;
    pkt(10, 8, 0, 0);
    pkt(10, 8, 0, 1);
    idle(2); out_ready = 1; idle(20);
    chk(drop_cnt == 2, "R8", "drop count", drop_cnt, 2);
    chk(ovf_cnt == 1, "R8", "overflow unchanged", ovf_cnt, 1);

    // R6: random back-pressure
    rand_rdy = 1;
    for (int p = 0; p < 6; p++) begin
      pkt(1 + p % 3, 1 + p, p % 8, 0);
      idle(2);
    end
    idle(30);
    rand_rdy = 0; out_ready = 1; idle(20);
    chk(good_cnt == 14, "R6", "good after back-pressure", good_cnt, 14);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule